// File: doc/BRIEF.md
# Predicated 16-bit Arithmetic Unit with Flag Update

This block is a purely combinational arithmetic unit for a small load-store processor. It takes two source operands, a five-bit operation code and the present zero and carry flags. From these it produces a result, a write strobe for the destination register, and the zero and carry values that the flag register should load next. The two low bits of the code select one of four arithmetic kinds: add, subtract, add with carry-in, and subtract with borrow-in. The three high bits select an execution gate that is tested against the incoming flags.

When the gate is open, the write strobe is high and both flags are recomputed from the arithmetic. When the gate is closed, the write strobe is low and both flags pass through unchanged. A program can therefore make any arithmetic step conditional, without a branch. The surrounding core registers the flags and performs the register write. The block holds no state and has no clock. It has no states or transitions: each output is a function of the present inputs only.

Top module: `pred_alu`

## Requirements
- R1: Kind 00 (add): result = (src_a + src_b) mod 2^16, and carry_next is bit 16 of the full sum.
- R2: Kind 01 (subtract): result = (src_a - src_b) mod 2^16, and carry_next is 1 exactly when src_a < src_b (a borrow).
- R3: Kind 10 (add with carry): result = (src_a + src_b + carry_in) mod 2^16, and carry_next is bit 16 of that sum.
- R4: Kind 11 (subtract with borrow): result = (src_a - src_b - carry_in) mod 2^16, and carry_next is 1 exactly when src_a < src_b + carry_in.
- R5: Whenever the operation executes, zero_next is 1 exactly when the 16-bit result is zero.
- R6: Gate code 000 (op_code[4:2]) always executes: wr_en = 1.
- R7: Gate code 001 executes only when zero_in = 1. Gate code 010 executes only when zero_in = 0.
- R8: Gate code 011 executes only when carry_in = 1, for all four arithmetic kinds.
- R9: Gate codes 100 through 111 never execute: wr_en = 0 and both flags are unchanged.
- R10: When the operation does not execute, wr_en = 0, zero_next = zero_in and carry_next = carry_in. The result port still shows the arithmetic value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 16 | First operand (minuend for the subtract kinds) |
| src_b | input | 16 | Second operand |
| op_code | input | 5 | [4:2] execution gate, [1:0] arithmetic kind |
| zero_in | input | 1 | Present zero flag |
| carry_in | input | 1 | Present carry flag |
| result | output | 16 | Arithmetic result |
| wr_en | output | 1 | Destination write strobe, high when the operation executes |
| zero_next | output | 1 | Zero flag value to load |
| carry_next | output | 1 | Carry flag value to load |

## Verification
The bound checker examines the gate on every input change. It confirms that each gate code opens the write strobe against the correct flag, and that a closed gate passes both flags through. It also confirms that the zero flag agrees with the result, and that plain add and subtract agree with the full-width sum. The bench's scenarios cover the rest. These are the carry and borrow values at the wrap points (0xFFFF + 1, 0 - 1, and subtract with borrow on equal operands). They also show that the carry-in is consumed by the add-with-carry and subtract-with-borrow kinds, and that the result port still holds the arithmetic value when the gate is shut.

// File: rtl/pred_alu_pkg.sv
package pred_alu_pkg;

    typedef enum logic [1:0] {
        ARITH_ADD = 2'b00,
        ARITH_SUB = 2'b01,
        ARITH_ADC = 2'b10,
        ARITH_SBC = 2'b11
    } arith_kind_e;

    typedef enum logic [2:0] {
        GATE_ALWAYS   = 3'b000,
        GATE_Z_SET    = 3'b001,
        GATE_Z_CLEAR  = 3'b010,
        GATE_C_SET    = 3'b011,
        GATE_SHUT_4   = 3'b100,
        GATE_SHUT_5   = 3'b101,
        GATE_SHUT_6   = 3'b110,
        GATE_SHUT_7   = 3'b111
    } gate_code_e;

    localparam int KIND_W = 2;
    localparam int GATE_W = 3;
    localparam int OP_W   = KIND_W + GATE_W;

endpackage

// File: rtl/pred_alu_gate.sv
module pred_alu_gate
    import pred_alu_pkg::*;
(
    input  logic [GATE_W-1:0] gate_bits,
    input  logic              zero_in,
    input  logic              carry_in,
    output logic              fire
);

    gate_code_e gate;

    always_comb begin
        gate = gate_code_e'(gate_bits);
        fire = 1'b0;
        unique case (gate)
            GATE_ALWAYS:  fire = 1'b1;
            GATE_Z_SET:   fire = zero_in;
            GATE_Z_CLEAR: fire = ~zero_in;
            GATE_C_SET:   fire = carry_in;
            GATE_SHUT_4,
            GATE_SHUT_5,
            GATE_SHUT_6,
            GATE_SHUT_7:  fire = 1'b0;
        endcase
    end

endmodule

// File: rtl/pred_alu_arith.sv
module pred_alu_arith
    import pred_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [KIND_W-1:0] kind_bits,
    input  logic              carry_in,
    output logic [DATA_W-1:0] sum,
    output logic              carry_flag
);

    localparam int FULL_W = DATA_W + 1;

    arith_kind_e       kind;
    logic              is_sub;
    logic              use_cin;
    logic [DATA_W-1:0] b_eff;
    logic              cin_eff;
    logic [FULL_W-1:0] full;

    always_comb begin
        kind    = arith_kind_e'(kind_bits);
        is_sub  = 1'b0;
        use_cin = 1'b0;
        unique case (kind)
            ARITH_ADD: begin is_sub = 1'b0; use_cin = 1'b0; end
            ARITH_SUB: begin is_sub = 1'b1; use_cin = 1'b0; end
            ARITH_ADC: begin is_sub = 1'b0; use_cin = 1'b1; end
            ARITH_SBC: begin is_sub = 1'b1; use_cin = 1'b1; end
        endcase
        // Subtraction is done as a + ~b + 1; a borrow-in removes the +1.
        b_eff   = is_sub ? ~opnd_b : opnd_b;
        if (is_sub) cin_eff = use_cin ? ~carry_in : 1'b1;
        else        cin_eff = use_cin ?  carry_in : 1'b0;
        full       = {1'b0, opnd_a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin_eff};
        sum        = full[DATA_W-1:0];
        // For subtraction the carry flag means borrow, so the adder carry is inverted.
        carry_flag = is_sub ? ~full[DATA_W] : full[DATA_W];
    end

endmodule

// File: rtl/pred_alu_flags.sv
module pred_alu_flags #(
    parameter int DATA_W = 16
) (
    input  logic              fire,
    input  logic [DATA_W-1:0] sum,
    input  logic              carry_flag,
    input  logic              zero_in,
    input  logic              carry_in,
    output logic              wr_en,
    output logic              zero_next,
    output logic              carry_next
);

    logic sum_is_zero;

    always_comb begin
        sum_is_zero = (sum == '0);
        wr_en       = fire;
        zero_next   = fire ? sum_is_zero : zero_in;
        carry_next  = fire ? carry_flag  : carry_in;
    end

endmodule

// File: rtl/pred_alu.sv
module pred_alu
    import pred_alu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [OP_W-1:0]   op_code,
    input  logic              zero_in,
    input  logic              carry_in,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              zero_next,
    output logic              carry_next
);

    logic              fire;
    logic [DATA_W-1:0] sum;
    logic              carry_flag;

    pred_alu_gate u_gate (
        .gate_bits (op_code[OP_W-1:KIND_W]),
        .zero_in   (zero_in),
        .carry_in  (carry_in),
        .fire      (fire)
    );

    pred_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .opnd_a     (src_a),
        .opnd_b     (src_b),
        .kind_bits  (op_code[KIND_W-1:0]),
        .carry_in   (carry_in),
        .sum        (sum),
        .carry_flag (carry_flag)
    );

    pred_alu_flags #(.DATA_W(DATA_W)) u_flags (
        .fire       (fire),
        .sum        (sum),
        .carry_flag (carry_flag),
        .zero_in    (zero_in),
        .carry_in   (carry_in),
        .wr_en      (wr_en),
        .zero_next  (zero_next),
        .carry_next (carry_next)
    );

    assign result = sum;

endmodule

// File: rtl/pred_alu_chk.sv
module pred_alu_chk #(
    parameter int DATA_W = 16
) (
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [4:0]        op_code,
    input logic              zero_in,
    input logic              carry_in,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic              zero_next,
    input logic              carry_next
);

    logic [DATA_W:0] add_full;
    logic [DATA_W:0] sub_full;

    always_comb begin
        add_full = {1'b0, src_a} + {1'b0, src_b};
        sub_full = {1'b0, src_a} - {1'b0, src_b};
        if (!$isunknown({src_a, src_b, op_code, zero_in, carry_in,
                         result, wr_en, zero_next, carry_next})) begin
            a_r6_always_writes: assert (op_code[4:2] != 3'b000 || wr_en)
                else $error("R6 gate 000 did not write");
            a_r7_zero_gate: assert (op_code[4:2] != 3'b001 || wr_en == zero_in)
                else $error("R7 gate 001 mismatch");
            a_r7_nonzero_gate: assert (op_code[4:2] != 3'b010 || wr_en == !zero_in)
                else $error("R7 gate 010 mismatch");
            a_r8_carry_gate: assert (op_code[4:2] != 3'b011 || wr_en == carry_in)
                else $error("R8 gate 011 mismatch");
            a_r9_shut: assert (!op_code[4] || !wr_en)
                else $error("R9 gate 1xx wrote");
            a_r10_hold_flags: assert (wr_en || (zero_next == zero_in && carry_next == carry_in))
                else $error("R10 flags moved while gate shut");
            a_r5_zero_flag: assert (!wr_en || zero_next == (result == '0))
                else $error("R5 zero flag disagrees with result");
            a_r1_add: assert (!(wr_en && op_code[1:0] == 2'b00) || {carry_next, result} == add_full)
                else $error("R1 add mismatch");
            a_r2_sub: assert (!(wr_en && op_code[1:0] == 2'b01) ||
                              (result == sub_full[DATA_W-1:0] && carry_next == (src_a < src_b)))
                else $error("R2 subtract mismatch");
        end
    end

endmodule

bind pred_alu pred_alu_chk #(.DATA_W(DATA_W)) u_pred_alu_chk (
    .src_a      (src_a),
    .src_b      (src_b),
    .op_code    (op_code),
    .zero_in    (zero_in),
    .carry_in   (carry_in),
    .result     (result),
    .wr_en      (wr_en),
    .zero_next  (zero_next),
    .carry_next (carry_next)
);

// File: tb/pred_alu_bench.sv
module pred_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_a = '0;
    logic [15:0] src_b = '0;
    logic [4:0]  op_code = '0;
    logic        zero_in = 1'b0;
    logic        carry_in = 1'b0;
    logic [15:0] result;
    logic        wr_en;
    logic        zero_next;
    logic        carry_next;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pred_alu u_pred_alu (
        .src_a      (src_a),
        .src_b      (src_b),
        .op_code    (op_code),
        .zero_in    (zero_in),
        .carry_in   (carry_in),
        .result     (result),
        .wr_en      (wr_en),
        .zero_next  (zero_next),
        .carry_next (carry_next)
    );

    // Behavioural reference built on integers from the requirements.
    task automatic model(input logic [15:0] a, input logic [15:0] b, input logic [4:0] op,
                         input logic z, input logic c,
                         output logic [15:0] r, output logic w,
                         output logic zn, output logic cn);
        int ai, bi, ci, full;
        logic cf;
        ai = int'(a); bi = int'(b); ci = c ? 1 : 0;
        case (op[1:0])
            2'd0: full = ai + bi;
            2'd1: full = ai - bi;
            2'd2: full = ai + bi + ci;
            default: full = ai - bi - ci;
        endcase
        if (op[1:0] == 2'd0 || op[1:0] == 2'd2) cf = (full > 65535);
        else                                    cf = (full < 0);
        r = full[15:0];
        case (op[4:2])
            3'd0: w = 1'b1;
            3'd1: w = z;
            3'd2: w = !z;
            3'd3: w = c;
            default: w = 1'b0;
        endcase
        zn = w ? (r == 16'h0) : z;
        cn = w ? cf : c;
    endtask

    function automatic string tag_of(input logic [4:0] op);
        if (op[4])            return "R9";
        if (op[4:2] == 3'd3)  return "R8";
        if (op[4:2] != 3'd0)  return "R7";
        case (op[1:0])
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [4:0] op,
                         input logic z, input logic c, input string note);
        logic [15:0] er;
        logic ew, ez, ec;
        string tg;
        @(posedge clk);
        src_a = a; src_b = b; op_code = op; zero_in = z; carry_in = c;
        @(negedge clk);
        model(a, b, op, z, c, er, ew, ez, ec);
        tg = tag_of(op);
        checks++;
        if (result !== er || wr_en !== ew || zero_next !== ez || carry_next !== ec) begin
            errors++;
            $display("FAIL %s/%s op=%b a=%h b=%h z=%b c=%b: got r=%h w=%b z=%b c=%b exp r=%h w=%b z=%b c=%b",
                     tg, note, op, a, b, z, c, result, wr_en, zero_next, carry_next,
                     er, ew, ez, ec);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Quiet state: all-zero inputs give add 0+0, executing with zero set (R5, R6).
        @(negedge clk);
        checks++;
        if (result !== 16'h0 || wr_en !== 1'b1 || zero_next !== 1'b1 || carry_next !== 1'b0) begin
            errors++;
            $display("FAIL R6 idle: got r=%h w=%b z=%b c=%b exp r=0000 w=1 z=1 c=0",
                     result, wr_en, zero_next, carry_next);
        end
        // R1 add, including wrap to zero with carry out (R5 zero flag).
        apply(16'h1234, 16'h0111, 5'b000_00, 1'b0, 1'b1, "R1 plain");
        apply(16'hFFFF, 16'h0001, 5'b000_00, 1'b0, 1'b0, "R1 R5 wrap");
        // R2 subtract: borrow and equal operands.
        apply(16'h0000, 16'h0001, 5'b000_01, 1'b0, 1'b0, "R2 borrow");
        apply(16'h4444, 16'h4444, 5'b000_01, 1'b0, 1'b1, "R2 R5 equal");
        // R3 add with carry.
        apply(16'hFFFF, 16'h0000, 5'b000_10, 1'b0, 1'b1, "R3 cin wrap");
        apply(16'h0100, 16'h0200, 5'b000_10, 1'b1, 1'b0, "R3 no cin");
        // R4 subtract with borrow.
        apply(16'h0000, 16'h0000, 5'b000_11, 1'b0, 1'b1, "R4 borrow in");
        apply(16'h5000, 16'h4FFF, 5'b000_11, 1'b0, 1'b1, "R4 to zero");
        apply(16'h5000, 16'h4FFF, 5'b000_11, 1'b1, 1'b0, "R4 no borrow");
        // R7 zero gates in both flag states; R10 flags held when shut.
        apply(16'h0003, 16'h0004, 5'b001_00, 1'b1, 1'b0, "R7 zset open");
        apply(16'h0003, 16'h0004, 5'b001_00, 1'b0, 1'b1, "R7 R10 zset shut");
        apply(16'h0009, 16'h0009, 5'b010_01, 1'b0, 1'b1, "R7 zclr open");
        apply(16'h0009, 16'h0009, 5'b010_01, 1'b1, 1'b0, "R7 R10 zclr shut");
        // R8 carry gate over every kind.
        for (int k = 0; k < 4; k++) begin
            apply(16'h8001, 16'h8000, {3'b011, 2'(k)}, 1'b0, 1'b1, "R8 open");
            apply(16'h8001, 16'h8000, {3'b011, 2'(k)}, 1'b1, 1'b0, "R8 R10 shut");
        end
        // R9 never-execute gates with every flag pairing.
        for (int g = 4; g < 8; g++) begin
            for (int f = 0; f < 4; f++) begin
                apply(16'hFFFF, 16'h0001, {3'(g), 2'(f)}, f[0], f[1], "R9 R10 shut");
            end
        end
        // Mixed patterns over every code.
        for (int n = 0; n < 600; n++) begin
            apply(16'($urandom), 16'($urandom), 5'($urandom), 1'($urandom), 1'($urandom), "mix");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired: got timeout exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule